// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block carries a processor from normal execution into an exception handler. While idle it looks at four request lines (bus fault, break, non-maskable interrupt, maskable interrupt). It gates the two interrupt kinds against the current status word, picks one winner and captures the machine context for that winner. It then walks a fixed sequence of steps over several cycles.

In the save cycle it writes back to the core:
- the return address, into the register that suits the cause;
- the exception-status word;
- a user/kernel stack pointer swap, when needed;
- the status word shifted one level down its three-level mode stack;
- a request to clear any pending delay-slot count.

It then reads the handler address from the vector table through a request/grant/read-valid port, waiting as long as memory needs, and loads it as the new PC.

The core's register file owns all the architectural state. The sequencer only receives current values and drives write strobes with new values, so it fits beside an existing register file without duplicating it.

Top module: `exc_entry_seq`

## Requirements
- R1: Requests are sampled only while idle, with priority bus fault over break over NMI over maskable interrupt. Requests raised while busy are ignored.
- R2: A maskable interrupt is accepted only if status bit 5 (interrupt enable) is 1 and `irq_lock_i` is 0.
- R3: An NMI is accepted only if its mask flag is 1. The flag is status bit 9 when `version_i` < 32 and status bit 10 otherwise.
- R4: The vector is `trap_vec_i` for break, 0 for NMI, `fault_vec_i` for bus fault and `irq_vec_i` for a maskable interrupt.
- R5: In the save cycle, NMI asserts `nrp_we_o` with `ret_addr_o` = PC. Every other cause asserts `erp_we_o` with `ret_addr_o` = PC minus the captured delay-slot count. `dslot_clr_o` is asserted when that count is nonzero.
- R6: In the save cycle `exs_we_o` is 1 and `exs_o` holds the low 8 vector bits in bits 15:8, with all other bits 0.
- R7: When status bit 8 (user mode) is 1, the save cycle asserts `usp_we_o` with `usp_o` = captured SP, and `sp_we_o` with `sp_o` = captured kernel SP. Otherwise neither strobe is asserted.
- R8: In the save cycle `ccs_we_o` is 1. For NMI, the R3 mask bit is first cleared. Then `ccs_o` bits 31:30 keep the old bits 31:30, bits 29:10 take the old bits 19:0, and bits 9:0 are 0.
- R9: The cycle after the save cycle, `rd_req_o` rises with `rd_addr_o` = vector base + 4 × vector. Both are held until `rd_gnt_i` is 1.
- R10: After the grant, the first `rd_rvalid_i` captures `rd_rdata_i`. The next cycle asserts `pc_we_o` and `done_o` for one cycle with `pc_o` = that data. `busy_o` is 1 from the save cycle through the done cycle and 0 afterwards.
- R11: All context inputs are captured at acceptance. Changing them later does not affect any write-back value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bflt_req_i | input | 1 | Bus fault request |
| brk_req_i | input | 1 | Break request |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| irq_req_i | input | 1 | Maskable interrupt request |
| irq_lock_i | input | 1 | Interrupt lock active |
| version_i | input | 8 | Architecture version |
| fault_vec_i | input | 8 | Vector latched by the MMU for a bus fault |
| trap_vec_i | input | 8 | Break vector |
| irq_vec_i | input | 8 | Vector from the interrupt controller |
| pc_i | input | 32 | Current PC |
| ccs_i | input | 32 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| ksp_i | input | 32 | Kernel stack pointer |
| ebp_i | input | 32 | Vector table base |
| dslot_i | input | 2 | Delay-slot count |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | One-cycle completion pulse |
| erp_we_o | output | 1 | Write exception return register |
| nrp_we_o | output | 1 | Write NMI return register |
| ret_addr_o | output | 32 | Return address value |
| exs_we_o | output | 1 | Write exception-status register |
| exs_o | output | 32 | Exception-status value |
| ccs_we_o | output | 1 | Write status word |
| ccs_o | output | 32 | New status word |
| sp_we_o | output | 1 | Write stack pointer |
| sp_o | output | 32 | New stack pointer |
| usp_we_o | output | 1 | Write user stack pointer |
| usp_o | output | 32 | User stack pointer value |
| dslot_clr_o | output | 1 | Clear delay-slot count |
| rd_req_o | output | 1 | Vector read request |
| rd_addr_o | output | 32 | Vector read address |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_rvalid_i | input | 1 | Read data valid |
| rd_rdata_i | input | 32 | Read data |
| pc_we_o | output | 1 | Load PC |
| pc_o | output | 32 | Handler address |

## Verification
Two things can fall in the same cycle: request arbitration and the gating of each interrupt kind. Both interrupt lines are raised together, alone and alongside bus fault or break, with status words that enable or mask each one. The bench judges the winner through the vector carried in the status write and the read address.

Requests can also arrive while an entry is running. The bench raises NMI and a maskable interrupt during the read wait. It then confirms that no save strobe reappears, the handler still loads, and the block returns to idle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    CAUSE_IRQ  = 2'd0,
    CAUSE_NMI  = 2'd1,
    CAUSE_BRK  = 2'd2,
    CAUSE_BFLT = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_FETCH,
    ST_WAIT,
    ST_LOAD
  } state_e;

  // push the three-level mode stack held in the status word
  function automatic logic [WORD_W-1:0] mode_push(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] t;
    t = (w << 12) >> 2;
    return ((w & 32'hC000_0000) | t) & ~32'h0000_03FF;
  endfunction
endpackage

// File: rtl/exc_accept.sv
module exc_accept
  import exc_entry_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned VER_W     = 8,
  parameter int unsigned I_BIT     = 5,
  parameter int unsigned M_OLD_BIT = 9,
  parameter int unsigned M_NEW_BIT = 10,
  parameter int unsigned VER_SPLIT = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              bflt_req_i,
  input  logic              brk_req_i,
  input  logic              nmi_req_i,
  input  logic              irq_req_i,
  input  logic              irq_lock_i,
  input  logic [VER_W-1:0]  version_i,
  input  logic [WORD_W-1:0] ccs_i,
  input  logic [VEC_W-1:0]  fault_vec_i,
  input  logic [VEC_W-1:0]  trap_vec_i,
  input  logic [VEC_W-1:0]  irq_vec_i,
  output logic              take_o,
  output cause_e            cause_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              m_new_o
);
  logic nmi_mask, nmi_ok, irq_ok;

  assign m_new_o  = (version_i >= VER_W'(VER_SPLIT));
  assign nmi_mask = m_new_o ? ccs_i[M_NEW_BIT] : ccs_i[M_OLD_BIT];
  assign nmi_ok   = nmi_req_i & nmi_mask;
  assign irq_ok   = irq_req_i & ccs_i[I_BIT] & ~irq_lock_i;
  assign take_o   = idle_i & (bflt_req_i | brk_req_i | nmi_ok | irq_ok);

  always_comb begin
    cause_o = CAUSE_IRQ;
    vec_o   = irq_vec_i;
    if (bflt_req_i) begin
      cause_o = CAUSE_BFLT;
      vec_o   = fault_vec_i;
    end else if (brk_req_i) begin
      cause_o = CAUSE_BRK;
      vec_o   = trap_vec_i;
    end else if (nmi_ok) begin
      cause_o = CAUSE_NMI;
      vec_o   = '0;
    end
  end

  // R1
  take_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> idle_i);
  // R2
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cause_o == CAUSE_IRQ) |-> (ccs_i[I_BIT] && !irq_lock_i));
  // R1
  nmi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cause_o == CAUSE_IRQ) |-> !nmi_ok);
endmodule

// File: rtl/exc_ctx.sv
module exc_ctx
  import exc_entry_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned DS_W      = 2,
  parameter int unsigned U_BIT     = 8,
  parameter int unsigned M_OLD_BIT = 9,
  parameter int unsigned M_NEW_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  cause_e            cause_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              m_new_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] ccs_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] ksp_i,
  input  logic [WORD_W-1:0] ebp_i,
  input  logic [DS_W-1:0]   dslot_i,
  output cause_e            cause_o,
  output logic [WORD_W-1:0] ret_addr_o,
  output logic [WORD_W-1:0] exs_o,
  output logic [WORD_W-1:0] ccs_o,
  output logic              user_o,
  output logic [WORD_W-1:0] usp_o,
  output logic [WORD_W-1:0] ksp_o,
  output logic              dslot_hit_o,
  output logic [WORD_W-1:0] vec_addr_o
);
  localparam int unsigned IDX_W = 8;

  cause_e            cause_q;
  logic [VEC_W-1:0]  vec_q;
  logic              m_new_q;
  logic [WORD_W-1:0] pc_q, ccs_q, sp_q, ksp_q, ebp_q;
  logic [DS_W-1:0]   ds_q;
  logic [WORD_W-1:0] ccs_m;
  logic [IDX_W-1:0]  idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_IRQ;
      vec_q   <= '0;
      m_new_q <= 1'b0;
      pc_q    <= '0;
      ccs_q   <= '0;
      sp_q    <= '0;
      ksp_q   <= '0;
      ebp_q   <= '0;
      ds_q    <= '0;
    end else if (take_i) begin
      cause_q <= cause_i;
      vec_q   <= vec_i;
      m_new_q <= m_new_i;
      pc_q    <= pc_i;
      ccs_q   <= ccs_i;
      sp_q    <= sp_i;
      ksp_q   <= ksp_i;
      ebp_q   <= ebp_i;
      ds_q    <= dslot_i;
    end
  end

  always_comb begin
    ccs_m = ccs_q;
    if (cause_q == CAUSE_NMI) begin
      if (m_new_q) ccs_m[M_NEW_BIT] = 1'b0;
      else         ccs_m[M_OLD_BIT] = 1'b0;
    end
  end

  assign idx         = IDX_W'(vec_q);
  assign cause_o     = cause_q;
  assign ccs_o       = mode_push(ccs_m);
  assign ret_addr_o  = (cause_q == CAUSE_NMI) ? pc_q : pc_q - WORD_W'(ds_q);
  assign exs_o       = WORD_W'({idx, 8'h00});
  assign user_o      = ccs_q[U_BIT];
  assign usp_o       = sp_q;
  assign ksp_o       = ksp_q;
  assign dslot_hit_o = (ds_q != '0);
  assign vec_addr_o  = ebp_q + (WORD_W'(vec_q) << 2);
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
  import exc_entry_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              rd_gnt_i,
  input  logic              rd_rvalid_i,
  input  logic [WORD_W-1:0] rd_rdata_i,
  output logic              idle_o,
  output logic              save_o,
  output logic              rd_req_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [WORD_W-1:0] handler_o
);
  state_e            state_q, state_d;
  logic [WORD_W-1:0] handler_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (take_i) state_d = ST_SAVE;
      ST_SAVE:  state_d = ST_FETCH;
      ST_FETCH: if (rd_gnt_i) state_d = ST_WAIT;
      ST_WAIT:  if (rd_rvalid_i) state_d = ST_LOAD;
      ST_LOAD:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      handler_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAIT && rd_rvalid_i) handler_q <= rd_rdata_i;
    end
  end

  assign idle_o    = (state_q == ST_IDLE);
  assign save_o    = (state_q == ST_SAVE);
  assign rd_req_o  = (state_q == ST_FETCH);
  assign done_o    = (state_q == ST_LOAD);
  assign busy_o    = !idle_o;
  assign handler_o = handler_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_gnt_i) |=> rd_req_o);
  // R10
  load_from_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rd_rvalid_i));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned VER_W     = 8,
  parameter int unsigned DS_W      = 2,
  parameter int unsigned I_BIT     = 5,
  parameter int unsigned U_BIT     = 8,
  parameter int unsigned M_OLD_BIT = 9,
  parameter int unsigned M_NEW_BIT = 10,
  parameter int unsigned VER_SPLIT = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bflt_req_i,
  input  logic              brk_req_i,
  input  logic              nmi_req_i,
  input  logic              irq_req_i,
  input  logic              irq_lock_i,
  input  logic [VER_W-1:0]  version_i,
  input  logic [VEC_W-1:0]  fault_vec_i,
  input  logic [VEC_W-1:0]  trap_vec_i,
  input  logic [VEC_W-1:0]  irq_vec_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] ccs_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] ksp_i,
  input  logic [WORD_W-1:0] ebp_i,
  input  logic [DS_W-1:0]   dslot_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              erp_we_o,
  output logic              nrp_we_o,
  output logic [WORD_W-1:0] ret_addr_o,
  output logic              exs_we_o,
  output logic [WORD_W-1:0] exs_o,
  output logic              ccs_we_o,
  output logic [WORD_W-1:0] ccs_o,
  output logic              sp_we_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              usp_we_o,
  output logic [WORD_W-1:0] usp_o,
  output logic              dslot_clr_o,
  output logic              rd_req_o,
  output logic [WORD_W-1:0] rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_rvalid_i,
  input  logic [WORD_W-1:0] rd_rdata_i,
  output logic              pc_we_o,
  output logic [WORD_W-1:0] pc_o
);
  logic             idle, save, take, m_new, user, ds_hit;
  cause_e           acc_cause, cur_cause;
  logic [VEC_W-1:0] acc_vec;

  exc_accept #(
    .VEC_W(VEC_W), .VER_W(VER_W), .I_BIT(I_BIT),
    .M_OLD_BIT(M_OLD_BIT), .M_NEW_BIT(M_NEW_BIT), .VER_SPLIT(VER_SPLIT)
  ) i_accept (
    .clk_i, .rst_ni,
    .idle_i(idle),
    .bflt_req_i, .brk_req_i, .nmi_req_i, .irq_req_i, .irq_lock_i,
    .version_i, .ccs_i, .fault_vec_i, .trap_vec_i, .irq_vec_i,
    .take_o(take), .cause_o(acc_cause), .vec_o(acc_vec), .m_new_o(m_new)
  );

  exc_ctx #(
    .VEC_W(VEC_W), .DS_W(DS_W), .U_BIT(U_BIT),
    .M_OLD_BIT(M_OLD_BIT), .M_NEW_BIT(M_NEW_BIT)
  ) i_ctx (
    .clk_i, .rst_ni,
    .take_i(take), .cause_i(acc_cause), .vec_i(acc_vec), .m_new_i(m_new),
    .pc_i, .ccs_i, .sp_i, .ksp_i, .ebp_i, .dslot_i,
    .cause_o(cur_cause), .ret_addr_o, .exs_o, .ccs_o,
    .user_o(user), .usp_o, .ksp_o(sp_o), .dslot_hit_o(ds_hit),
    .vec_addr_o(rd_addr_o)
  );

  exc_fsm i_fsm (
    .clk_i, .rst_ni,
    .take_i(take), .rd_gnt_i, .rd_rvalid_i, .rd_rdata_i,
    .idle_o(idle), .save_o(save), .rd_req_o, .done_o, .busy_o,
    .handler_o(pc_o)
  );

  assign erp_we_o    = save & (cur_cause != CAUSE_NMI);
  assign nrp_we_o    = save & (cur_cause == CAUSE_NMI);
  assign exs_we_o    = save;
  assign ccs_we_o    = save;
  assign sp_we_o     = save & user;
  assign usp_we_o    = save & user;
  assign dslot_clr_o = save & ds_hit;
  assign pc_we_o     = done_o;

  // R5
  one_writer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({erp_we_o, nrp_we_o, pc_we_o}));
  // R9
  save_then_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erp_we_o || nrp_we_o) |=> rd_req_o);
  // R9
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_gnt_i) |=> $stable(rd_addr_o));
  // R8
  ccs_low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccs_we_o |-> (ccs_o[9:0] == 10'd0 && !ccs_o[U_BIT]));
endmodule

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic bflt_req, brk_req, nmi_req, irq_req, irq_lock;
  logic [7:0] version, fault_vec, trap_vec, irq_vec;
  logic [31:0] pc, ccs, sp, ksp, ebp;
  logic [1:0] dslot;
  logic busy, done, erp_we, nrp_we, exs_we, ccs_we, sp_we, usp_we, dslot_clr;
  logic [31:0] ret_addr, exs, ccs_new, sp_new, usp, rd_addr, pc_new;
  logic rd_req, rd_gnt, rd_rvalid, pc_we;
  logic [31:0] rd_rdata;

  int n_chk = 0, n_fail = 0;

  exc_entry_seq i_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .bflt_req_i(bflt_req), .brk_req_i(brk_req), .nmi_req_i(nmi_req), .irq_req_i(irq_req),
    .irq_lock_i(irq_lock), .version_i(version),
    .fault_vec_i(fault_vec), .trap_vec_i(trap_vec), .irq_vec_i(irq_vec),
    .pc_i(pc), .ccs_i(ccs), .sp_i(sp), .ksp_i(ksp), .ebp_i(ebp), .dslot_i(dslot),
    .busy_o(busy), .done_o(done), .erp_we_o(erp_we), .nrp_we_o(nrp_we),
    .ret_addr_o(ret_addr), .exs_we_o(exs_we), .exs_o(exs),
    .ccs_we_o(ccs_we), .ccs_o(ccs_new), .sp_we_o(sp_we), .sp_o(sp_new),
    .usp_we_o(usp_we), .usp_o(usp), .dslot_clr_o(dslot_clr),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_gnt_i(rd_gnt),
    .rd_rvalid_i(rd_rvalid), .rd_rdata_i(rd_rdata),
    .pc_we_o(pc_we), .pc_o(pc_new)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // -1 none, 0 irq, 1 nmi, 2 break, 3 bus fault
  function automatic int exp_cause(bit bf, bit bk, bit nm, bit iq, logic [31:0] c,
                                   logic [7:0] ver, bit lk);
    bit mflag;
    mflag = (ver < 8'd32) ? c[9] : c[10];
    if (bf) return 3;
    if (bk) return 2;
    if (nm && mflag) return 1;
    if (iq && c[5] && !lk) return 0;
    return -1;
  endfunction

  function automatic logic [31:0] exp_ccs(logic [31:0] old, bit is_nmi, logic [7:0] ver);
    logic [31:0] o, r;
    o = old;
    if (is_nmi) begin
      if (ver < 8'd32) o[9] = 1'b0; else o[10] = 1'b0;
    end
    r = '0;
    r[31:30] = o[31:30];
    r[29:10] = o[19:0];
    return r;
  endfunction

  task automatic no_save_strobes(input string req);
    chk(req, {erp_we, nrp_we, exs_we, ccs_we, sp_we, usp_we, dslot_clr}, 32'd0);
  endtask

  task automatic run_entry(input bit bf, input bit bk, input bit nm, input bit iq,
                           input logic [31:0] c, input logic [7:0] ver, input bit lk,
                           input logic [31:0] p, input logic [31:0] s, input logic [31:0] ks,
                           input logic [31:0] eb, input logic [1:0] ds,
                           input logic [7:0] fv, input logic [7:0] tv, input logic [7:0] iv,
                           input int gw, input int rw, input logic [31:0] hnd, input bit poke);
    int cs;
    logic [7:0] v;
    @(negedge clk);
    bflt_req = bf; brk_req = bk; nmi_req = nm; irq_req = iq;
    ccs = c; version = ver; irq_lock = lk; pc = p; sp = s; ksp = ks; ebp = eb;
    dslot = ds; fault_vec = fv; trap_vec = tv; irq_vec = iv;
    cs = exp_cause(bf, bk, nm, iq, c, ver, lk);
    v = (cs == 3) ? fv : (cs == 2) ? tv : (cs == 1) ? 8'd0 : iv;
    @(negedge clk);
    bflt_req = 0; brk_req = 0; nmi_req = 0; irq_req = 0;
    // R11: scramble context after acceptance
    pc = $urandom; ccs = $urandom; sp = $urandom; ksp = $urandom; ebp = $urandom;
    dslot = 2'($urandom); fault_vec = 8'($urandom); trap_vec = 8'($urandom); irq_vec = 8'($urandom);
    if (cs < 0) begin
      chk((iq && !nm) ? "R2 not taken" : "R3 not taken", 32'(busy), 32'd0);
      no_save_strobes("R2_R3 no strobes");
      return;
    end
    chk("R10 busy in save", 32'(busy), 32'd1);
    chk("R5 erp_we", 32'(erp_we), 32'(cs != 1));
    chk("R5 nrp_we", 32'(nrp_we), 32'(cs == 1));
    chk("R5 R11 ret_addr", ret_addr, (cs == 1) ? p : p - 32'(ds));
    chk("R5 dslot_clr", 32'(dslot_clr), 32'(ds != 0));
    chk("R6 exs_we", 32'(exs_we), 32'd1);
    chk("R4 R6 exs", exs, {16'h0, v, 8'h00});
    chk("R7 sp_we", 32'(sp_we), 32'(c[8]));
    chk("R7 usp_we", 32'(usp_we), 32'(c[8]));
    if (c[8]) begin
      chk("R7 R11 usp", usp, s);
      chk("R7 R11 sp", sp_new, ks);
    end
    chk("R8 ccs_we", 32'(ccs_we), 32'd1);
    chk("R8 R11 ccs", ccs_new, exp_ccs(c, cs == 1, ver));
    @(negedge clk);
    chk("R9 rd_req", 32'(rd_req), 32'd1);
    chk("R4 R9 rd_addr", rd_addr, eb + {22'd0, v, 2'b00});
    for (int i = 0; i < gw; i++) begin
      @(negedge clk);
      chk("R9 req held", 32'(rd_req), 32'd1);
      chk("R9 addr held", rd_addr, eb + {22'd0, v, 2'b00});
    end
    rd_gnt = 1'b1;
    @(negedge clk);
    rd_gnt = 1'b0;
    chk("R9 req dropped", 32'(rd_req), 32'd0);
    if (poke) begin
      nmi_req = 1'b1; irq_req = 1'b1; bflt_req = 1'b1; ccs = 32'hFFFF_FFFF; irq_lock = 1'b0;
    end
    for (int i = 0; i < rw; i++) begin
      @(negedge clk);
      no_save_strobes("R1 ignored while busy");
      chk("R10 busy in wait", 32'(busy), 32'd1);
      chk("R10 no early pc_we", 32'(pc_we), 32'd0);
    end
    rd_rvalid = 1'b1; rd_rdata = hnd;
    @(negedge clk);
    rd_rvalid = 1'b0; rd_rdata = $urandom;
    nmi_req = 0; irq_req = 0; bflt_req = 0;
    chk("R10 pc_we", 32'(pc_we), 32'd1);
    chk("R10 done", 32'(done), 32'd1);
    chk("R10 pc value", pc_new, hnd);
    @(negedge clk);
    chk("R10 done pulse", 32'(done), 32'd0);
    chk("R10 idle after", 32'(busy), 32'd0);
    no_save_strobes("R1 no re-entry");
  endtask

  initial begin
    #750000;
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 act=timeout exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 0;
    {bflt_req, brk_req, nmi_req, irq_req, irq_lock, rd_gnt, rd_rvalid} = '0;
    version = 0; fault_vec = 0; trap_vec = 0; irq_vec = 0;
    pc = 0; ccs = 0; sp = 0; ksp = 0; ebp = 0; dslot = 0; rd_rdata = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset busy", 32'(busy), 32'd0);
    chk("R10 reset done", 32'(done), 32'd0);
    chk("R9 reset rd_req", 32'(rd_req), 32'd0);
    no_save_strobes("R5 reset strobes");
    rst_n = 1;

    // R2 irq, user mode, no delay slot
    run_entry(0,0,0,1, 32'h0000_0120, 8'd40, 0, 32'h1000, 32'hAAAA_0000, 32'h8000_0000,
              32'h4000_0000, 2'd0, 8'h11, 8'h22, 8'h33, 0, 1, 32'hC000_1234, 0);
    // R2 interrupt enable clear / lock set
    run_entry(0,0,0,1, 32'h0000_0100, 8'd40, 0, 32'h1000, 0, 0, 0, 2'd0, 1, 2, 3, 0, 1, 0, 0);
    run_entry(0,0,0,1, 32'h0000_0020, 8'd40, 1, 32'h1000, 0, 0, 0, 2'd0, 1, 2, 3, 0, 1, 0, 0);
    // R3 old version, bit 9 set; then new version with only bit 9
    run_entry(0,0,1,0, 32'h0000_0200, 8'd10, 0, 32'h2000, 32'h1, 32'h2, 32'h100, 2'd2,
              1, 2, 3, 1, 2, 32'hDEAD_BEEF, 0);
    run_entry(0,0,1,0, 32'h0000_0200, 8'd40, 0, 32'h2000, 0, 0, 0, 2'd0, 1, 2, 3, 0, 1, 0, 0);
    // R1 NMI over irq (new version bit 10)
    run_entry(0,0,1,1, 32'hC000_0520, 8'd32, 0, 32'h3000, 32'h5, 32'h6, 32'h200, 2'd1,
              1, 2, 3, 2, 1, 32'h0BAD_F00D, 1);
    // R1 bus fault over break, R4 vectors
    run_entry(1,1,1,1, 32'hFFFF_FFFF, 8'd10, 0, 32'h4000, 32'h7, 32'h8, 32'h300, 2'd3,
              8'hFF, 8'h44, 8'h55, 0, 3, 32'h1111_2222, 1);
    run_entry(0,1,0,0, 32'h0000_0000, 8'd10, 0, 32'h0000_0001, 32'h9, 32'hA, 32'hFFFF_FF00, 2'd1,
              8'h01, 8'h80, 8'h02, 1, 1, 32'h3333_4444, 0);

    for (int k = 0; k < 60; k++) begin
      run_entry(($urandom % 8) == 0, ($urandom % 8) == 0, $urandom % 2, $urandom % 2,
                $urandom, ($urandom % 2) ? 8'd12 : 8'd48, ($urandom % 4) == 0,
                $urandom, $urandom, $urandom, $urandom, 2'($urandom),
                8'($urandom), 8'($urandom), 8'($urandom),
                $urandom % 3, 1 + $urandom % 3, $urandom, $urandom % 2);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule